// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one column command into the ordered list of column indices that a double-data-rate memory burst visits. A start pulse carries a 9-bit starting column, a burst-length selector and an ordering mode. The block then produces two column indices per clock, one for the rising-edge beat and one for the falling-edge beat. It flags every valid pair and marks the final pair of the burst.

The ordering is confined to an aligned block whose size equals the burst length. The low log2(BL) column bits rotate, either by addition or by exclusive-or with the beat number. The bits above them repeat the starting column unchanged. A stop input ends a burst early. A fresh start pulse during a burst abandons the old sequence and begins the new one. Length and mode are captured on the start pulse, so changes to those inputs while a burst runs have no effect on it.

Top module: `ddr_burst_col_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls with no start, `beat_valid` and `beat_last` are 0.
- R2: `burst_len_sel` codes 0, 1, 2 and 3 select burst lengths 2, 4, 8 and 16. A burst shows BL/2 consecutive cycles with `beat_valid` high. `beat_last` is high only in the final one, and `beat_valid` is low in the cycle after it unless a new start arrived.
- R3: With `interleave` = 0, beat i (0-based) addresses the column whose low log2(BL) bits equal (start low bits + i) modulo BL. For example, start 5 with BL 8 yields 5,6,7,0,1,2,3,4.
- R4: With `interleave` = 1, beat i addresses the column whose low log2(BL) bits equal (start low bits) XOR i. For example, start 5 with BL 8 yields 5,4,7,6,1,0,3,2.
- R5: The column bits above the low log2(BL) bits equal those of the starting column on every beat.
- R6: In each valid cycle, `col_even` carries beat 2p and `col_odd` carries beat 2p+1, where p counts valid cycles from 0.
- R7: A start pulse sampled at a rising edge makes the first pair appear on the outputs right after that edge.
- R8: `stop` high at an edge with no start drives `beat_valid` low after that edge and ends the burst with no `beat_last`.
- R9: A start during a burst abandons the old sequence and presents pair 0 of the new burst after that edge. If start and stop are high together, start wins.
- R10: Changes to `start_col`, `burst_len_sel` or `interleave` during a burst, without a start, do not alter that burst's sequence or length.
- R11: `stop` while no burst runs leaves `beat_valid` and `beat_last` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a burst with the inputs below |
| stop | input | 1 | End the running burst early |
| start_col | input | 9 | Starting column address |
| burst_len_sel | input | 2 | Burst length code: 0=2, 1=4, 2=8, 3=16 |
| interleave | input | 1 | 0 = sequential ordering, 1 = interleaved ordering |
| col_even | output | 9 | Column for the rising-edge beat of the pair |
| col_odd | output | 9 | Column for the falling-edge beat of the pair |
| beat_valid | output | 1 | Pair on the column outputs is valid |
| beat_last | output | 1 | Pair is the final pair of the burst |

## Verification
The assertions take it that `start`, `stop` and the configuration inputs are settled, known values at each rising edge. They also take it that reset is applied before the first start. The bench changes inputs only on falling edges and holds reset high from time zero. It uses a fixed-seed random mix of columns, lengths, modes, early stops, restarts and mid-burst configuration changes. Directed cases add block-edge starting columns, start together with stop, and stop while idle.

// File: rtl/ddr_col_pkg.sv
package ddr_col_pkg;
  typedef enum logic [1:0] {
    BL_2  = 2'd0,
    BL_4  = 2'd1,
    BL_8  = 2'd2,
    BL_16 = 2'd3
  } bl_sel_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_XOR = 1'b1
  } order_e;

  // log2 of the burst length selected by a code
  function automatic int bl_log(input bl_sel_e sel);
    return int'(sel) + 1;
  endfunction
endpackage

// File: rtl/ddr_col_ctrl.sv
module ddr_col_ctrl
  import ddr_col_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int LOG_MAX = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic [COL_W-1:0]     col_i,
  input  bl_sel_e              bl_i,
  input  order_e               ord_i,
  output logic                 emit_o,
  output logic                 final_o,
  output logic [COL_W-1:0]     base_o,
  output bl_sel_e              bl_o,
  output order_e               ord_o,
  output logic [LOG_MAX-2:0]   pair_o
);
  localparam int PAIR_W = LOG_MAX - 1;

  logic              busy_q;
  logic [PAIR_W-1:0] pair_q;
  logic [COL_W-1:0]  col_q;
  bl_sel_e           bl_q;
  order_e            ord_q;
  logic [PAIR_W-1:0] pair_last;

  // a start takes the live inputs; otherwise the captured burst settings
  always_comb begin
    base_o    = start_i ? col_i : col_q;
    bl_o      = start_i ? bl_i  : bl_q;
    ord_o     = start_i ? ord_i : ord_q;
    pair_o    = start_i ? '0    : pair_q;
    emit_o    = start_i | (busy_q & ~stop_i);
    pair_last = PAIR_W'((1 << int'(bl_o)) - 1);
    final_o   = (pair_o == pair_last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      pair_q <= '0;
      col_q  <= '0;
      bl_q   <= BL_2;
      ord_q  <= ORD_SEQ;
    end else begin
      busy_q <= emit_o & ~final_o;
      if (emit_o) pair_q <= pair_o + 1'b1;
      if (start_i) begin
        col_q <= col_i;
        bl_q  <= bl_i;
        ord_q <= ord_i;
      end
    end
  end

  AST_BUSY_ADVANCED: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (pair_q != '0)); // R2
  AST_IDLE_AFTER_FINAL: assert property (@(posedge clk) disable iff (rst)
    (emit_o && final_o) |=> !busy_q); // R2
endmodule

// File: rtl/ddr_col_lane.sv
module ddr_col_lane
  import ddr_col_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int LOG_MAX = 4,
  parameter int LANE    = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [COL_W-1:0]   base_i,
  input  bl_sel_e            bl_i,
  input  order_e             ord_i,
  input  logic [LOG_MAX-2:0] pair_i,
  output logic [COL_W-1:0]   col_o
);
  localparam logic LANE_BIT = 1'(LANE);

  logic [LOG_MAX-1:0] beat;
  logic [LOG_MAX-1:0] low;
  logic [LOG_MAX-1:0] off;
  logic [COL_W-1:0]   mask;
  logic [COL_W-1:0]   nxt;

  always_comb begin
    beat = {pair_i, LANE_BIT};
    low  = base_i[LOG_MAX-1:0];
    for (int b = 0; b < COL_W; b++) mask[b] = (b < bl_log(bl_i));
    off  = (ord_i == ORD_XOR) ? (low ^ beat) : (low + beat);
    nxt  = (base_i & ~mask) | (COL_W'(off) & mask);
  end

  always_ff @(posedge clk) begin
    if (rst)         col_o <= '0;
    else if (load_i) col_o <= nxt;
  end
endmodule

// File: rtl/ddr_burst_col_seq.sv
module ddr_burst_col_seq
  import ddr_col_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int LOG_MAX = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [1:0]       burst_len_sel,
  input  logic             interleave,
  output logic [COL_W-1:0] col_even,
  output logic [COL_W-1:0] col_odd,
  output logic             beat_valid,
  output logic             beat_last
);
  localparam int LANES = 2;

  logic               emit;
  logic               fin;
  logic [COL_W-1:0]   base;
  bl_sel_e            bl_cur;
  order_e             ord_cur;
  logic [LOG_MAX-2:0] pair;
  logic [COL_W-1:0]   lane_col [LANES];

  ddr_col_ctrl #(.COL_W(COL_W), .LOG_MAX(LOG_MAX)) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .stop_i  (stop),
    .col_i   (start_col),
    .bl_i    (bl_sel_e'(burst_len_sel)),
    .ord_i   (order_e'(interleave)),
    .emit_o  (emit),
    .final_o (fin),
    .base_o  (base),
    .bl_o    (bl_cur),
    .ord_o   (ord_cur),
    .pair_o  (pair)
  );

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    ddr_col_lane #(.COL_W(COL_W), .LOG_MAX(LOG_MAX), .LANE(gl)) i_lane (
      .clk    (clk),
      .rst    (rst),
      .load_i (emit),
      .base_i (base),
      .bl_i   (bl_cur),
      .ord_i  (ord_cur),
      .pair_i (pair),
      .col_o  (lane_col[gl])
    );
  end

  assign col_even = lane_col[0];
  assign col_odd  = lane_col[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_valid <= 1'b0;
      beat_last  <= 1'b0;
    end else begin
      beat_valid <= emit;
      beat_last  <= emit & fin;
    end
  end

  AST_START_GIVES_PAIR: assert property (@(posedge clk) disable iff (rst)
    start |=> beat_valid); // R7
  AST_STOP_DROPS: assert property (@(posedge clk) disable iff (rst)
    (stop && !start) |=> (!beat_valid && !beat_last)); // R8
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    beat_last |-> beat_valid); // R2
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (beat_last && !start) |=> !beat_valid); // R2
  AST_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_last && !start && !stop) |=>
      (beat_valid && col_even[COL_W-1:LOG_MAX] == $past(col_even[COL_W-1:LOG_MAX]))); // R5
  AST_LANE_PARITY: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> (col_odd[0] != col_even[0])); // R6
endmodule

// File: tb/test_ddr_burst_col_seq.sv
module test_ddr_burst_col_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0, stop = 1'b0, interleave = 1'b0;
  logic [8:0] start_col = '0;
  logic [1:0] burst_len_sel = '0;
  logic [8:0] col_even, col_odd;
  logic       beat_valid, beat_last;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ddr_burst_col_seq i_ddr_burst_col_seq (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .start_col(start_col),
    .burst_len_sel(burst_len_sel), .interleave(interleave),
    .col_even(col_even), .col_odd(col_odd),
    .beat_valid(beat_valid), .beat_last(beat_last));

  function automatic logic [8:0] exp_col(input logic [8:0] s, input logic [1:0] b,
                                         input bit il, input int beat);
    int bl   = 2 << b;
    int mask = bl - 1;
    int low  = int'(s) & mask;
    int off  = il ? (low ^ beat) : ((low + beat) % bl);
    return 9'((int'(s) & ~mask) | (off & mask));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic launch(input logic [8:0] c, input logic [1:0] b, input bit il);
    start = 1'b1; start_col = c; burst_len_sel = b; interleave = il;
  endtask

  // mode 0: run to end, 1: stop after pair 'at', 2: return at pair 'at'
  task automatic follow(input logic [8:0] c, input logic [1:0] b, input bit il,
                        input int mode, input int at, input bit chg);
    int np = 1 << b;
    string rq = il ? "R4" : "R3";
    for (int p = 0; p < np; p++) begin
      @(negedge clk);
      start = 1'b0; stop = 1'b0;
      if (chg) begin  // R10: disturb configuration mid-burst
        start_col = 9'($urandom); burst_len_sel = 2'($urandom); interleave = ~il;
      end
      chk(beat_valid == 1'b1, "R2", "valid", int'(beat_valid), 1);
      chk(col_even == exp_col(c, b, il, 2*p), rq, "even col", col_even, exp_col(c, b, il, 2*p));
      chk(col_odd == exp_col(c, b, il, 2*p+1), "R6", "odd col", col_odd, exp_col(c, b, il, 2*p+1));
      chk((col_even >> (b+1)) == (c >> (b+1)), "R5", "upper bits",
          int'(col_even >> (b+1)), int'(c >> (b+1)));
      chk(beat_last == (p == np-1), "R2", "last", int'(beat_last), int'(p == np-1));
      if (mode == 2 && p == at) return;
      if (mode == 1 && p == at && p < np-1) begin
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(!beat_valid && !beat_last, "R8", "stopped", int'(beat_valid), 0);
        return;
      end
    end
    @(negedge clk);
    chk(beat_valid == 1'b0, "R2", "idle after last", int'(beat_valid), 0);
  endtask

  task automatic burst(input logic [8:0] c, input logic [1:0] b, input bit il,
                       input int mode, input int at, input bit chg);
    @(negedge clk);
    launch(c, b, il);
    follow(c, b, il, mode, at, chg);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!beat_valid && !beat_last, "R1", "in reset", int'(beat_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!beat_valid && !beat_last, "R1", "after reset", int'(beat_valid), 0);
    // R11: stop while idle
    stop = 1'b1;
    repeat (3) @(negedge clk);
    chk(!beat_valid && !beat_last, "R11", "idle stop", int'(beat_valid), 0);
    stop = 1'b0;
    // R3 / R4 examples, R7 first pair right after start
    burst(9'd5, 2'd2, 1'b0, 0, 0, 1'b0);
    burst(9'd5, 2'd2, 1'b1, 0, 0, 1'b0);
    // each length, block-edge columns
    for (int b = 0; b < 4; b++) begin
      burst(9'h1FF, 2'(b), 1'b0, 0, 0, 1'b0);
      burst(9'h1F0, 2'(b), 1'b1, 0, 0, 1'b0);
    end
    // R8 early stop
    burst(9'd37, 2'd3, 1'b0, 1, 2, 1'b0);
    // R9 restart mid-burst, then start together with stop
    burst(9'd100, 2'd3, 1'b1, 2, 1, 1'b0);
    launch(9'd203, 2'd1, 1'b0);
    follow(9'd203, 2'd1, 1'b0, 2, 0, 1'b0);
    launch(9'd77, 2'd2, 1'b1);
    stop = 1'b1;
    follow(9'd77, 2'd2, 1'b1, 0, 0, 1'b0);
    // R10 configuration changes mid-burst
    burst(9'd300, 2'd3, 1'b0, 0, 0, 1'b1);
    // random mix
    for (int n = 0; n < 400; n++) begin
      int kind = int'($urandom % 8);
      logic [1:0] b = 2'($urandom);
      int np = 1 << b;
      burst(9'($urandom), b, 1'($urandom), (kind == 0) ? 1 : 0,
            int'($urandom % np), kind == 1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule